// File: doc/BRIEF.md
# Six-Digit Time Display Segment Decoder

This block turns a 24-hour time value, given as six separate BCD digit fields (tens and units of hours, minutes and seconds), into six seven-segment patterns, one for each display position. It is purely combinational. Every output follows its input within the same cycle, and nothing inside the block holds a value.

Each digit position has its own decoder, sized to the width and legal range of that digit. The tens-of-hours path takes two bits and shows 0 through 3, so the same path can also serve a day-of-month tens digit. The tens-of-minutes and tens-of-seconds paths take three bits and show 0 through 5. The three units paths take four bits and show 0 through 9. Any code above a path's legal maximum turns that digit fully dark, so no input produces a stray or partial glyph. A parameter selects the output polarity, which lets the same block drive common-anode or common-cathode displays.

Top module: `seg_time_decoder`

## Requirements
- R1: The outputs depend only on the present inputs. A change on any digit input shows on the matching segment output within the same cycle, with no clock edge needed.
- R2: The tens-of-hours path shows the glyphs 0, 1 and 2 for the input codes 0, 1 and 2.
- R3: The tens-of-hours path shows the glyph 3 for input code 3. No code on this 2-bit path is blanked.
- R4: The tens-of-minutes and tens-of-seconds paths show the glyphs 0 to 5 for the 3-bit codes 0 to 5.
- R5: On the tens-of-minutes and tens-of-seconds paths, the codes 6 and 7 light no segment.
- R6: The hours, minutes and seconds units paths show the glyphs 0 to 9 for the 4-bit codes 0 to 9.
- R7: On the units paths, the codes 10 to 15 light no segment.
- R8: Each output is 7 bits wide, ordered {g,f,e,d,c,b,a}, with bit 0 = a. When ACTIVE_LOW = 0, a lit segment is 1. In hex the glyphs are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. A blank digit is 00.
- R9: When ACTIVE_LOW = 1, every output bit is the inverse of the R8 value, and a blank digit reads 7F.
- R10: Every time from 00:00:00 to 23:59:59 appears on the six outputs as the correct glyphs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hr_tens_i | input | 2 | Tens digit of hours (range 0 to 3) |
| hr_units_i | input | 4 | Units digit of hours |
| mn_tens_i | input | 3 | Tens digit of minutes |
| mn_units_i | input | 4 | Units digit of minutes |
| sc_tens_i | input | 3 | Tens digit of seconds |
| sc_units_i | input | 4 | Units digit of seconds |
| hr_tens_seg_o | output | 7 | Segments for the tens-of-hours display |
| hr_units_seg_o | output | 7 | Segments for the units-of-hours display |
| mn_tens_seg_o | output | 7 | Segments for the tens-of-minutes display |
| mn_units_seg_o | output | 7 | Segments for the units-of-minutes display |
| sc_tens_seg_o | output | 7 | Segments for the tens-of-seconds display |
| sc_units_seg_o | output | 7 | Segments for the units-of-seconds display |

## Verification
A sweep of 256 patterns drives every code of every path. The six paths receive different, staggered codes at the same time, so a wiring swap between positions or a wrong input width shows up as a mismatch. The same sweep covers the blank codes of the 3-bit and 4-bit paths. Those codes separate a strict range check from a decoder that leaves them as don't-cares and lets a glyph through. It also covers code 3 on the hours path, which must not be blanked. A walk through all 86,400 seconds of a day checks the bank as a time display. A second instance built with inverted polarity is compared on every pattern, which confirms that blank reads as all ones there. One check changes an input between clock edges to show that no register sits in the path.

// File: rtl/seg_time_pkg.sv
package seg_time_pkg;

   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;

   localparam seg_t SEG_DARK = '0;

   // Glyph lookup in {g,f,e,d,c,b,a} order, active-high; only 0..9 meaningful
   function automatic seg_t glyph_of(input logic [3:0] digit);
      seg_t s;
      unique case (digit)
         4'd0: s = 7'b0111111;
         4'd1: s = 7'b0000110;
         4'd2: s = 7'b1011011;
         4'd3: s = 7'b1001111;
         4'd4: s = 7'b1100110;
         4'd5: s = 7'b1101101;
         4'd6: s = 7'b1111101;
         4'd7: s = 7'b0000111;
         4'd8: s = 7'b1111111;
         4'd9: s = 7'b1101111;
         default: s = SEG_DARK;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/seg_range_decoder.sv
module seg_range_decoder
   import seg_time_pkg::*;
#(
   parameter int IN_W    = 4,
   parameter int MAX_VAL = 9
) (
   input  logic [IN_W-1:0] code_i,
   output seg_t            seg_o
);
   localparam int CODES = 1 << IN_W;

   if (IN_W < 1 || IN_W > 4) begin : g_bad_width
      $error("seg_range_decoder: IN_W must be 1..4");
   end
   if (MAX_VAL < 0 || MAX_VAL > 9 || MAX_VAL >= CODES) begin : g_bad_max
      $error("seg_range_decoder: MAX_VAL must fit IN_W and lie in 0..9");
   end

   logic [3:0] code_ext;
   logic       in_range;

   assign code_ext = 4'(code_i);

   if (MAX_VAL == CODES - 1) begin : g_full_range
      // every code is a legal digit: no comparator needed
      assign in_range = 1'b1;
   end else begin : g_clipped
      assign in_range = (int'(code_ext) <= MAX_VAL);
   end

   assign seg_o = in_range ? glyph_of(code_ext) : SEG_DARK;

endmodule

// File: rtl/seg_polarity.sv
module seg_polarity
   import seg_time_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  seg_t lit_i,
   output seg_t drive_o
);
   if (ACTIVE_LOW) begin : g_invert
      assign drive_o = ~lit_i;
   end else begin : g_pass
      assign drive_o = lit_i;
   end
endmodule

// File: rtl/seg_time_decoder.sv
module seg_time_decoder
   import seg_time_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic [1:0] hr_tens_i,
   input  logic [3:0] hr_units_i,
   input  logic [2:0] mn_tens_i,
   input  logic [3:0] mn_units_i,
   input  logic [2:0] sc_tens_i,
   input  logic [3:0] sc_units_i,
   output logic [6:0] hr_tens_seg_o,
   output logic [6:0] hr_units_seg_o,
   output logic [6:0] mn_tens_seg_o,
   output logic [6:0] mn_units_seg_o,
   output logic [6:0] sc_tens_seg_o,
   output logic [6:0] sc_units_seg_o
);
   localparam int POSITIONS = 6;

   // position index: 0 hr tens, 1 hr units, 2 mn tens, 3 mn units, 4 sc tens, 5 sc units
   function automatic int width_of(input int p);
      if (p == 0) return 2;
      else if (p == 2 || p == 4) return 3;
      else return 4;
   endfunction

   function automatic int max_of(input int p);
      if (p == 0) return 3;
      else if (p == 2 || p == 4) return 5;
      else return 9;
   endfunction

   logic [3:0] raw   [POSITIONS];
   seg_t       lit   [POSITIONS];
   seg_t       drive [POSITIONS];

   assign raw[0] = {2'b00, hr_tens_i};
   assign raw[1] = hr_units_i;
   assign raw[2] = {1'b0, mn_tens_i};
   assign raw[3] = mn_units_i;
   assign raw[4] = {1'b0, sc_tens_i};
   assign raw[5] = sc_units_i;

   for (genvar p = 0; p < POSITIONS; p++) begin : g_pos
      localparam int W = width_of(p);
      localparam int M = max_of(p);

      seg_range_decoder #(.IN_W(W), .MAX_VAL(M)) u_dec (
         .code_i (raw[p][W-1:0]),
         .seg_o  (lit[p])
      );

      seg_polarity #(.ACTIVE_LOW(ACTIVE_LOW)) u_pol (
         .lit_i   (lit[p]),
         .drive_o (drive[p])
      );
   end

   assign hr_tens_seg_o  = drive[0];
   assign hr_units_seg_o = drive[1];
   assign mn_tens_seg_o  = drive[2];
   assign mn_units_seg_o = drive[3];
   assign sc_tens_seg_o  = drive[4];
   assign sc_units_seg_o = drive[5];

endmodule

// File: rtl/seg_time_decoder_chk.sv
module seg_time_decoder_chk #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input logic [1:0] hr_tens_i,
   input logic [3:0] hr_units_i,
   input logic [2:0] mn_tens_i,
   input logic [3:0] mn_units_i,
   input logic [2:0] sc_tens_i,
   input logic [3:0] sc_units_i,
   input logic [6:0] hr_tens_seg_o,
   input logic [6:0] hr_units_seg_o,
   input logic [6:0] mn_tens_seg_o,
   input logic [6:0] mn_units_seg_o,
   input logic [6:0] sc_tens_seg_o,
   input logic [6:0] sc_units_seg_o
);
   // lit views, independent of polarity
   logic [6:0] l_ht, l_hu, l_mt, l_mu, l_st, l_su;
   assign l_ht = ACTIVE_LOW ? ~hr_tens_seg_o  : hr_tens_seg_o;
   assign l_hu = ACTIVE_LOW ? ~hr_units_seg_o : hr_units_seg_o;
   assign l_mt = ACTIVE_LOW ? ~mn_tens_seg_o  : mn_tens_seg_o;
   assign l_mu = ACTIVE_LOW ? ~mn_units_seg_o : mn_units_seg_o;
   assign l_st = ACTIVE_LOW ? ~sc_tens_seg_o  : sc_tens_seg_o;
   assign l_su = ACTIVE_LOW ? ~sc_units_seg_o : sc_units_seg_o;

   always_comb begin
      // R3
      hr_three_lit_chk: assert (hr_tens_i != 2'd3 || $countones(l_ht) == 5);
      // R5
      mn_tens_blank_chk: assert (mn_tens_i < 3'd6 || l_mt == 7'd0);
      // R5
      sc_tens_blank_chk: assert (sc_tens_i < 3'd6 || l_st == 7'd0);
      // R7
      units_blank_chk: assert ((hr_units_i < 4'd10 || l_hu == 7'd0) &&
                               (mn_units_i < 4'd10 || l_mu == 7'd0) &&
                               (sc_units_i < 4'd10 || l_su == 7'd0));
      // R6
      units_legal_lit_chk: assert ((hr_units_i > 4'd9 || $countones(l_hu) >= 2) &&
                                   (mn_units_i > 4'd9 || $countones(l_mu) >= 2) &&
                                   (sc_units_i > 4'd9 || $countones(l_su) >= 2));
      // R8
      eight_full_chk: assert (hr_units_i != 4'd8 || l_hu == 7'h7F);
      // R2
      hr_tens_never_dark_chk: assert ($countones(l_ht) >= 2);
   end
endmodule

bind seg_time_decoder seg_time_decoder_chk #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (.*);

// File: tb/seg_time_decoder_tb.sv
module seg_time_decoder_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [1:0] ht;
   logic [3:0] hu, mu, su;
   logic [2:0] mt, st;
   logic [6:0] o_ht, o_hu, o_mt, o_mu, o_st, o_su;
   logic [6:0] n_ht, n_hu, n_mt, n_mu, n_st, n_su;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   seg_time_decoder #(.ACTIVE_LOW(1'b0)) u_dut (
      .hr_tens_i(ht), .hr_units_i(hu), .mn_tens_i(mt), .mn_units_i(mu),
      .sc_tens_i(st), .sc_units_i(su),
      .hr_tens_seg_o(o_ht), .hr_units_seg_o(o_hu), .mn_tens_seg_o(o_mt),
      .mn_units_seg_o(o_mu), .sc_tens_seg_o(o_st), .sc_units_seg_o(o_su));

   seg_time_decoder #(.ACTIVE_LOW(1'b1)) u_dut_lo (
      .hr_tens_i(ht), .hr_units_i(hu), .mn_tens_i(mt), .mn_units_i(mu),
      .sc_tens_i(st), .sc_units_i(su),
      .hr_tens_seg_o(n_ht), .hr_units_seg_o(n_hu), .mn_tens_seg_o(n_mt),
      .mn_units_seg_o(n_mu), .sc_tens_seg_o(n_st), .sc_units_seg_o(n_su));

   // reference: value and legal maximum -> active-high pattern
   function automatic logic [6:0] ref_seg(input int v, input int maxv);
      if (v > maxv) return 7'h00;
      case (v)
         0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
         4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
         8: return 7'h7F;  default: return 7'h6F;
      endcase
   endfunction

   function automatic string req_for(input int v, input int maxv, input string in_tag,
                                     input string out_tag);
      return (v > maxv) ? out_tag : in_tag;
   endfunction

   task automatic cmp(input logic [6:0] act, input logic [6:0] exp, input string req,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // compare all 12 outputs against the reference for current inputs
   task automatic check_all(input string ctx);
      logic [6:0] e;
      e = ref_seg(int'(ht), 3);
      cmp(o_ht, e, (ht == 2'd3) ? "R3" : "R2", {ctx, " hr_tens"});
      cmp(n_ht, ~e, "R9", {ctx, " hr_tens low"});
      e = ref_seg(int'(hu), 9);
      cmp(o_hu, e, req_for(int'(hu), 9, "R6", "R7"), {ctx, " hr_units"});
      cmp(n_hu, ~e, "R9", {ctx, " hr_units low"});
      e = ref_seg(int'(mt), 5);
      cmp(o_mt, e, req_for(int'(mt), 5, "R4", "R5"), {ctx, " mn_tens"});
      cmp(n_mt, ~e, "R9", {ctx, " mn_tens low"});
      e = ref_seg(int'(mu), 9);
      cmp(o_mu, e, req_for(int'(mu), 9, "R6", "R7"), {ctx, " mn_units"});
      cmp(n_mu, ~e, "R9", {ctx, " mn_units low"});
      e = ref_seg(int'(st), 5);
      cmp(o_st, e, req_for(int'(st), 5, "R4", "R5"), {ctx, " sc_tens"});
      cmp(n_st, ~e, "R9", {ctx, " sc_tens low"});
      e = ref_seg(int'(su), 9);
      cmp(o_su, e, req_for(int'(su), 9, "R6", "R7"), {ctx, " sc_units"});
      cmp(n_su, ~e, "R9", {ctx, " sc_units low"});
   endtask

   initial begin
      ht = '0; hu = '0; mt = '0; mu = '0; st = '0; su = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // reset-like start: all zero inputs show "00:00:00"
      check_all("R8 start");

      // R1: input change visible without any clock edge
      @(posedge clk); #2;
      hu = 4'd7; #1;
      cmp(o_hu, 7'h07, "R1", "same-cycle response");
      cmp(n_hu, 7'h78, "R1", "same-cycle response low");

      // staggered sweep of every code on every path (R2..R9)
      for (int i = 0; i < 256; i++) begin
         @(posedge clk); #2;
         ht = 2'(i);
         mt = 3'(i);
         st = 3'(i >> 3);
         hu = 4'(i);
         mu = 4'(i >> 4);
         su = 4'(i + 5);
         @(negedge clk);
         check_all("sweep");
      end

      // R10: every second of a day
      for (int t = 0; t < 86400; t++) begin
         @(posedge clk); #2;
         ht = 2'((t / 3600) / 10);
         hu = 4'((t / 3600) % 10);
         mt = 3'(((t / 60) % 60) / 10);
         mu = 4'(((t / 60) % 60) % 10);
         st = 3'((t % 60) / 10);
         su = 4'((t % 60) % 10);
         @(negedge clk);
         check_all("R10 day");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule